// File: doc/BRIEF.md
# Checksum-Capable Execute Unit

This block is the arithmetic unit of a small 16-bit processor's execute stage. It takes two operands that forwarding has already resolved, plus a 2-bit operation code, and produces a 16-bit result. The operations are plain addition, subtraction, passing the first operand through, and a checksum addition. In the checksum addition, a carry out of the top bit is added back into the bit-0 end of the sum (end-around carry). The combinational core sits behind a one-stage register, so every result can be checked clock by clock.

Next to the registered path sits a packet checksum accumulator. Its caller clears it, then pushes the received words one per cycle. The words are a district/candidate pair word, a data word and a checksum word. Each pushed word is folded into a running sum with the checksum addition. When the caller raises `acc_done`, the accumulator reports in the next cycle, and for that one cycle it flags whether the packet authenticates. A packet authenticates when it has exactly the expected number of words and its final sum is a ones'-complement zero.

The accumulator is a three-state machine:
- `ACC_EMPTY`: nothing accumulated, sum and count are zero.
- `ACC_SUM`: at least one word has been folded in.
- `ACC_REPORT`: a one-cycle report state.

Its transitions are:
- Push: `ACC_EMPTY`/`ACC_SUM` → `ACC_SUM`.
- Done: `ACC_EMPTY`/`ACC_SUM` → `ACC_REPORT`.
- Restart: `ACC_REPORT` → `ACC_SUM` when a push arrives in the report cycle.
- Drain: `ACC_REPORT` → `ACC_EMPTY` otherwise.
- Clear: any state → `ACC_EMPTY`. Clear has the highest priority.

Top module: `cksum_alu_unit`

## Requirements
- R1: With `op_sel` = 2'b00, the result is `opnd_a + opnd_b` modulo 2^16.
- R2: With `op_sel` = 2'b01, the result is `opnd_a - opnd_b` modulo 2^16.
- R3: With `op_sel` = 2'b10, the result is the checksum sum. If `opnd_a + opnd_b` carries out of bit 15, the result is the low 16 bits plus one; otherwise it is the plain sum. The folded carry is applied once, and it never produces a further carry.
- R4: With `op_sel` = 2'b11, the result equals `opnd_a`.
- R5: Timing of the registered result:
  - A cycle with `in_valid` high loads the result into `res_q`, and `res_valid` is high in the next cycle.
  - A cycle with `in_valid` low leaves `res_q` unchanged, and `res_valid` is low in the next cycle.
- R6: While `rst_n` is low, `res_q`, `res_valid`, `acc_sum`, `pkt_done` and `pkt_ok` are all zero, and the accumulator is in `ACC_EMPTY`.
- R7: Each cycle with `acc_push` high, and with `acc_clear` low and the unit not reporting, replaces the running sum with the R3 checksum sum of the running sum and `acc_word`. `acc_sum` shows the new value in the next cycle.
- R8: Report timing:
  - `acc_done` in `ACC_EMPTY` or `ACC_SUM` raises `pkt_done` for exactly the next cycle.
  - A word pushed in the same cycle as `acc_done` is included in the report.
  - During the report cycle, `acc_sum` shows the final sum.
- R9: `pkt_ok` is high only in the report cycle. It is high exactly when the final sum is 16'h0000 or 16'hFFFF and exactly PKT_WORDS (default 3) words were pushed.
- R10: `acc_clear` wins over `acc_push` and `acc_done`. In the next cycle, `acc_sum` is zero and no report occurs, and the word count restarts from zero.
- R11: Leaving the report cycle:
  - After the report cycle, the accumulator restarts from zero.
  - A push during the report cycle becomes the first word of a new packet, so `acc_sum` equals that word.
  - `acc_done` during the report cycle is ignored.
- R12: `acc_done` with no words pushed still produces a report, with `pkt_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 checksum add, 11 pass A |
| opnd_a | input | 16 | First operand (Rs) |
| opnd_b | input | 16 | Second operand (Rt) |
| res_q | output | 16 | Registered result |
| res_valid | output | 1 | `res_q` was loaded by the previous cycle |
| acc_clear | input | 1 | Empty the packet accumulator |
| acc_push | input | 1 | Fold `acc_word` into the running sum |
| acc_word | input | 16 | Received packet word |
| acc_done | input | 1 | Last word of the packet has been pushed |
| acc_sum | output | 16 | Running checksum sum |
| pkt_done | output | 1 | One-cycle report strobe |
| pkt_ok | output | 1 | Packet authenticated (meaningful with `pkt_done`) |

## Verification
The assertions watch, on every cycle, the timing relations of the two sequential parts:
- `res_valid` follows `in_valid` by one cycle, and `res_q` holds when no operation is issued.
- A report strobe lasts a single cycle and always follows a done request.
- `pkt_ok` never appears outside a report.
- A clear or a drained report leaves a zero sum.

The arithmetic itself, and in particular which carry cases fold in checksum mode, can only be shown by the bench, which compares against its own integer model. The same holds for the authentication decision on valid, corrupted and short packets, and for a push landing in the report cycle.

// File: rtl/cksum_alu_pkg.sv
package cksum_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CADD = 2'b10,
        OP_PASS = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        ACC_EMPTY  = 2'b00,
        ACC_SUM    = 2'b01,
        ACC_REPORT = 2'b10
    } acc_state_e;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import cksum_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int WIDE_W = DATA_W + 1;

    logic [WIDE_W-1:0] wide_sum;
    logic [DATA_W-1:0] folded;

    // End-around carry: a carry out means the low part is at most 2^W-2,
    // so adding it back once cannot carry again.
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b};
        folded   = wide_sum[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, wide_sum[DATA_W]};
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = wide_sum[DATA_W-1:0];
            OP_SUB:  y = a - b;
            OP_CADD: y = folded;
            OP_PASS: y = a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/alu_stage.sv
module alu_stage
    import cksum_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res_q,
    output logic              res_valid
);
    logic [DATA_W-1:0] comb_y;

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op (op),
        .a  (a),
        .b  (b),
        .y  (comb_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_q <= comb_y;
            end
        end
    end

    assert_valid_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    assert_idle_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_q));

endmodule

// File: rtl/cksum_acc.sv
module cksum_acc
    import cksum_alu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PKT_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] word,
    input  logic              done,
    output logic [DATA_W-1:0] sum,
    output logic              pkt_done,
    output logic              pkt_ok
);
    localparam int CNT_W = $clog2(PKT_WORDS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(PKT_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(PKT_WORDS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    acc_state_e        state_q, state_n;
    logic [DATA_W-1:0] sum_q, sum_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [DATA_W-1:0] folded_sum;
    logic [CNT_W-1:0]  cnt_inc;
    logic              sum_is_zero;

    alu_core #(.DATA_W(DATA_W)) u_fold (
        .op (OP_CADD),
        .a  (sum_q),
        .b  (word),
        .y  (folded_sum)
    );

    assign cnt_inc = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + CNT_ONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_EMPTY;
            sum_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            sum_q   <= sum_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        sum_n   = sum_q;
        cnt_n   = cnt_q;
        if (clear) begin
            state_n = ACC_EMPTY;
            sum_n   = '0;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ACC_EMPTY, ACC_SUM: begin
                    if (push) begin
                        sum_n   = folded_sum;
                        cnt_n   = cnt_inc;
                        state_n = ACC_SUM;
                    end
                    if (done) begin
                        state_n = ACC_REPORT;
                    end
                end
                ACC_REPORT: begin
                    if (push) begin
                        sum_n   = word;
                        cnt_n   = CNT_ONE;
                        state_n = ACC_SUM;
                    end else begin
                        sum_n   = '0;
                        cnt_n   = '0;
                        state_n = ACC_EMPTY;
                    end
                end
                default: begin
                    state_n = ACC_EMPTY;
                    sum_n   = '0;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sum_is_zero = (sum_q == '0) || (sum_q == '1);
        sum         = sum_q;
        pkt_done    = (state_q == ACC_REPORT);
        pkt_ok      = pkt_done && sum_is_zero && (cnt_q == CNT_GOOD);
    end

    assert_report_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    assert_report_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(done));

    assert_ok_in_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok |-> pkt_done);

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum == '0 && !pkt_done));

    assert_drain_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !push) |=> (sum == '0));

endmodule

// File: rtl/cksum_alu_unit.sv
module cksum_alu_unit
    import cksum_alu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PKT_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_q,
    output logic              res_valid,
    input  logic              acc_clear,
    input  logic              acc_push,
    input  logic [DATA_W-1:0] acc_word,
    input  logic              acc_done,
    output logic [DATA_W-1:0] acc_sum,
    output logic              pkt_done,
    output logic              pkt_ok
);
    alu_op_e op_dec;
    assign op_dec = alu_op_e'(op_sel);

    alu_stage #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op_dec),
        .a         (opnd_a),
        .b         (opnd_b),
        .res_q     (res_q),
        .res_valid (res_valid)
    );

    cksum_acc #(.DATA_W(DATA_W), .PKT_WORDS(PKT_WORDS)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (acc_clear),
        .push     (acc_push),
        .word     (acc_word),
        .done     (acc_done),
        .sum      (acc_sum),
        .pkt_done (pkt_done),
        .pkt_ok   (pkt_ok)
    );

endmodule

// File: tb/cksum_alu_unit_tb.sv
`timescale 1ns/1ps
module cksum_alu_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] res_q;
    logic        res_valid;
    logic        acc_clear = 1'b0, acc_push = 1'b0, acc_done = 1'b0;
    logic [15:0] acc_word = '0;
    logic [15:0] acc_sum;
    logic        pkt_done, pkt_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_tag = "R6";

    // Reference model state
    int m_res = 0, m_rv = 0, m_op = 0;
    int m_sum = 0, m_cnt = 0, m_rep = 0;

    always #4 clk = ~clk;

    cksum_alu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_q(res_q), .res_valid(res_valid),
        .acc_clear(acc_clear), .acc_push(acc_push), .acc_word(acc_word),
        .acc_done(acc_done), .acc_sum(acc_sum), .pkt_done(pkt_done), .pkt_ok(pkt_ok)
    );

    function automatic int cadd(int a, int b);
        int s = a + b;
        if (s > 65535) s = s - 65535;
        return s;
    endfunction

    function automatic int alu_ref(int op, int a, int b);
        case (op)
            0: return (a + b) % 65536;
            1: return (a - b + 65536) % 65536;
            2: return cadd(a, b);
            default: return a;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_res <= 0; m_rv <= 0; m_op <= 0;
            m_sum <= 0; m_cnt <= 0; m_rep <= 0;
        end else begin
            m_rv <= in_valid;
            if (in_valid) begin
                m_res <= alu_ref(op_sel, opnd_a, opnd_b);
                m_op  <= op_sel;
            end
            if (acc_clear) begin
                m_sum <= 0; m_cnt <= 0; m_rep <= 0;
            end else if (m_rep != 0) begin
                m_rep <= 0;
                m_sum <= acc_push ? int'(acc_word) : 0;
                m_cnt <= acc_push ? 1 : 0;
            end else begin
                if (acc_push) begin
                    m_sum <= cadd(m_sum, acc_word);
                    m_cnt <= m_cnt + 1;
                end
                m_rep <= acc_done;
            end
        end
    end

    task automatic chk(string tag, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", tag, cur_tag, act, exp_v, $time);
        end
    endtask

    // Per-cycle comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            string rtag;
            int exp_ok;
            if (!rst_n) begin
                chk("R6 res_q", res_q, 0);
                chk("R6 res_valid", res_valid, 0);
                chk("R6 acc_sum", acc_sum, 0);
                chk("R6 pkt_done", pkt_done, 0);
                chk("R6 pkt_ok", pkt_ok, 0);
            end else begin
                case (m_op)
                    0: rtag = "R1 add";
                    1: rtag = "R2 sub";
                    2: rtag = "R3 cadd";
                    default: rtag = "R4 pass";
                endcase
                chk(rtag, res_q, m_res);
                chk("R5 res_valid", res_valid, m_rv);
                chk("R7 acc_sum", acc_sum, m_sum);
                chk("R8 pkt_done", pkt_done, m_rep);
                exp_ok = (m_rep != 0 && (m_sum == 0 || m_sum == 65535) && m_cnt == 3) ? 1 : 0;
                chk("R9 pkt_ok", pkt_ok, exp_ok);
            end
        end
    end

    task automatic op(int o, int a, int b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'(o); opnd_a = 16'(a); opnd_b = 16'(b);
    endtask

    task automatic acc(bit clr, bit psh, int w, bit dn);
        @(negedge clk);
        acc_clear = clr; acc_push = psh; acc_word = 16'(w); acc_done = dn;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        acc_clear = 1'b0; acc_push = 1'b0; acc_done = 1'b0;
    endtask

    initial begin
        int w0, w1, ck;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";
        op(0, 16'h1234, 16'h1111); op(0, 16'hFFFF, 16'h0001);
        cur_tag = "R2";
        op(1, 16'h0005, 16'h0003); op(1, 16'h0000, 16'h0001);
        cur_tag = "R3";
        op(2, 16'hFFFF, 16'h0001); op(2, 16'hFFFF, 16'hFFFF);
        op(2, 16'h8000, 16'h8000); op(2, 16'h0102, 16'h0304);
        cur_tag = "R4";
        op(3, 16'hBEEF, 16'h1234);
        cur_tag = "R5";
        idle(); idle(); idle();

        cur_tag = "R9 valid packet";
        w0 = 16'h3A07; w1 = 16'h0042;
        ck = 65535 - cadd(w0, w1);
        acc(1, 0, 0, 0);
        acc(0, 1, w0, 0); acc(0, 1, w1, 0); acc(0, 1, ck, 1);
        idle(); idle();

        cur_tag = "R9 corrupted packet";
        acc(0, 1, w0, 0); acc(0, 1, w1 ^ 16'h0100, 0); acc(0, 1, ck, 0);
        acc(0, 0, 0, 1); idle(); idle();

        cur_tag = "R9 short zero packet";
        acc(0, 1, 0, 0); acc(0, 1, 0, 1); idle(); idle();

        cur_tag = "R10";
        acc(0, 1, w0, 0); acc(1, 1, w1, 1); idle();
        acc(0, 1, w0, 0); acc(0, 1, w1, 0); acc(0, 1, ck, 1); idle();

        cur_tag = "R11";
        acc(0, 1, w0, 0); acc(0, 1, w1, 0); acc(0, 1, ck, 1);
        acc(0, 1, 16'h5555, 1); acc(0, 0, 0, 0); idle(); idle();

        cur_tag = "R12";
        acc(1, 0, 0, 0); acc(0, 0, 0, 1); idle(); idle();

        cur_tag = "random";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            in_valid  = 1'($urandom_range(0, 3) != 0);
            op_sel    = 2'($urandom_range(0, 3));
            opnd_a    = 16'($urandom);
            opnd_b    = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom);
            acc_clear = 1'($urandom_range(0, 15) == 0);
            acc_push  = 1'($urandom_range(0, 1));
            acc_word  = 16'($urandom);
            acc_done  = 1'($urandom_range(0, 4) == 0);
        end
        idle(); idle(); idle();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule